// File: doc/BRIEF.md
# Cascaded Perceptron Pass/Fail Classifier

This block runs inference for a growing pyramid of threshold units and turns the result into a test decision for one analog device. The input is a vector of `DIM` signed fixed-point measurements. Layer 0 forms a weighted sum of those measurements plus a bias. Every later layer also receives the sum of the squared measurements and the ±1 outputs of all layers below it. Each layer outputs +1 when its sum is zero or positive and −1 otherwise. The topmost active layer is the network answer. +1 means nominal and −1 means faulty.

Two networks with separate weights are evaluated on the same vector, one after the other. Together they bound a guard band. If both networks agree, the device gets their class. If they disagree, the device lies in the band and is sent for retest.

Weights are loaded through a write port while the engine is idle. The number of active layers is chosen for each vector, so a pruned network can be run. Evaluation does one multiply-accumulate per clock. Its latency depends only on `DIM` and the depth that is used.

The control is one state machine, with these states and transitions:

- ST_IDLE goes to ST_SQR when a vector is accepted.
- ST_SQR accumulates the squared norm for `DIM` cycles, then goes to ST_LATCH.
- ST_LATCH stores the norm and goes to ST_MAC.
- ST_MAC runs one term per cycle and goes to ST_SIGN after the last term of a layer.
- ST_SIGN records the sign of the layer. It then goes back to ST_MAC for the next layer or the second network, or to ST_DONE after the top layer of the second network.
- ST_DONE holds the result and returns to ST_IDLE once the result is accepted.

Top module: `ccp_classifier`

## Requirements
- R1: Each layer forms its bias weight times 1 plus the weighted sum of its inputs. Its output is +1 when that sum is at or above zero and −1 when the sum is negative.
- R2: Input index 0 is the bias and indices 1..DIM are measurements 0..DIM-1. Index DIM+1 is the squared norm. Index DIM+2+m is the ±1 output of layer m, for m < k. Layer 0 uses only indices 0..DIM. Layer k (k ≥ 1) uses indices 0..DIM+1+k.
- R3: The squared norm and each layer sum accumulate in a 40-bit signed register. The terms are added in ascending index order, and the register saturates to [−2^39, 2^39−1] after every addition.
- R4: `cfg_depth` is sampled when a vector is accepted and gives the number of active layers. A value of 0 runs 1 layer and a value above MAX_LAYERS runs MAX_LAYERS layers. The topmost active layer is the network output.
- R5: `res_code` is 2'b01 (pass) when both networks give +1, 2'b10 (fail) when both give −1, and 2'b11 (retest) when they differ. It is never 2'b00 while `res_valid` is high.
- R6: `res_valid` rises exactly DIM+1+2·Σ_{k<D}(n_k+1) cycles after the accepting clock edge. Here D is the effective depth, n_0 = DIM+1 and n_k = DIM+2+k (with DIM=8: 29 cycles for D=1, 53 for D=2, 239 for D=8).
- R7: `in_ready` is high only when the engine is idle. A vector is taken on `in_valid && in_ready`. `in_valid` has no effect while the engine is busy.
- R8: The result stays on `res_valid` with a stable `res_code` until `res_ready` is high. The engine is idle in the cycle after the handshake.
- R9: A write with `wr_en` stores `wr_data` at network `wr_net`, layer `wr_layer` and input index `wr_index`, but only while `in_ready` is high. Writes at any other time, or with an index of DIM+MAX_LAYERS+1 or more, are ignored.
- R10: After reset, `in_ready` is 1, `res_valid` is 0 and every weight is zero, so the first vector yields pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Weight write strobe |
| wr_net | input | 1 | Network select for the write |
| wr_layer | input | $clog2(MAX_LAYERS) | Layer index for the write |
| wr_index | input | $clog2(DIM+MAX_LAYERS+1) | Input index for the write |
| wr_data | input | WGT_W | Signed weight value |
| cfg_depth | input | $clog2(MAX_LAYERS+1) | Number of active layers |
| in_valid | input | 1 | Measurement vector offered |
| in_ready | output | 1 | Engine idle and able to take a vector |
| in_meas | input | DIM*MEAS_W | Packed signed measurements; element i in bits [i*MEAS_W +: MEAS_W] |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted |
| res_code | output | 2 | 01 pass, 10 fail, 11 retest |

## Verification
The bound assertions check the handshake rules on every cycle:

- the result code is legal,
- the engine is never idle while a result is pending,
- the result is held stable until it is accepted,
- the engine leaves idle after an accept and returns to idle after a handshake.

The arithmetic can only be shown by the bench scenarios, which compare against an independent model. That covers the threshold at exactly zero, the feature ordering across layers, the effect of depth and its clamping, saturation that changes the decision, the exact latency, and the fact that writes and offered vectors are ignored while the engine is busy.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQR,
        ST_LATCH,
        ST_MAC,
        ST_SIGN,
        ST_DONE
    } ccp_state_e;

    localparam logic [1:0] CODE_PASS   = 2'b01;
    localparam logic [1:0] CODE_FAIL   = 2'b10;
    localparam logic [1:0] CODE_RETEST = 2'b11;
endpackage

// File: rtl/ccp_weight_bank.sv
`timescale 1ns/1ps
module ccp_weight_bank #(
    parameter int LAYERS = 8,
    parameter int TERMS  = 17,
    parameter int WGT_W  = 16,
    localparam int LW = $clog2(LAYERS),
    localparam int IW = $clog2(TERMS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_net,
    input  logic [LW-1:0]           wr_layer,
    input  logic [IW-1:0]           wr_index,
    input  logic signed [WGT_W-1:0] wr_data,
    input  logic                    rd_net,
    input  logic [LW-1:0]           rd_layer,
    input  logic [IW-1:0]           rd_index,
    output logic signed [WGT_W-1:0] rd_data
);
    logic signed [WGT_W-1:0] rd_word [2];

    for (genvar n = 0; n < 2; n++) begin : g_net
        logic signed [WGT_W-1:0] mem [LAYERS][TERMS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int l = 0; l < LAYERS; l++)
                    for (int t = 0; t < TERMS; t++)
                        mem[l][t] <= '0;
            end else if (wr_en && wr_net == 1'(n) && wr_index < IW'(TERMS)) begin
                mem[wr_layer][wr_index] <= wr_data;
            end
        end

        assign rd_word[n] = (rd_index < IW'(TERMS)) ? mem[rd_layer][rd_index] : '0;
    end

    assign rd_data = rd_word[rd_net];
endmodule

// File: rtl/ccp_mac_unit.sv
`timescale 1ns/1ps
module ccp_mac_unit #(
    parameter int A_W   = 16,
    parameter int B_W   = 40,
    parameter int ACC_W = 40,
    localparam int P_W = A_W + B_W,
    localparam int S_W = ((P_W > ACC_W) ? P_W : ACC_W) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    clr,
    input  logic signed [A_W-1:0]   a,
    input  logic signed [B_W-1:0]   b,
    output logic signed [ACC_W-1:0] acc
);
    localparam logic signed [S_W-1:0] SAT_HI = {{(S_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [S_W-1:0] SAT_LO = {{(S_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

    logic signed [P_W-1:0]   prod;
    logic signed [ACC_W-1:0] base;
    logic signed [S_W-1:0]   sum;
    logic signed [ACC_W-1:0] clamped;

    assign prod = a * b;
    assign base = clr ? '0 : acc;
    assign sum  = S_W'(base) + S_W'(prod);

    always_comb begin
        if (sum > SAT_HI)      clamped = SAT_HI[ACC_W-1:0];
        else if (sum < SAT_LO) clamped = SAT_LO[ACC_W-1:0];
        else                   clamped = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (en)  acc <= clamped;
        else if (clr) acc <= '0;
    end
endmodule

// File: rtl/ccp_classifier.sv
`timescale 1ns/1ps
module ccp_classifier import ccp_pkg::*; #(
    parameter int DIM        = 8,
    parameter int MAX_LAYERS = 8,
    parameter int MEAS_W     = 16,
    parameter int WGT_W      = 16,
    parameter int ACC_W      = 40,
    localparam int TERMS   = DIM + MAX_LAYERS + 1,
    localparam int IW      = $clog2(TERMS),
    localparam int LW      = $clog2(MAX_LAYERS),
    localparam int DEPTH_W = $clog2(MAX_LAYERS + 1),
    localparam int MI      = $clog2(DIM)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_net,
    input  logic [LW-1:0]         wr_layer,
    input  logic [IW-1:0]         wr_index,
    input  logic [WGT_W-1:0]      wr_data,
    input  logic [DEPTH_W-1:0]    cfg_depth,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DIM*MEAS_W-1:0] in_meas,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic [1:0]            res_code
);
    ccp_state_e state_q, state_d;

    logic signed [MEAS_W-1:0] meas_q [DIM];
    logic [LW-1:0]            last_layer_q, layer_q, depth_last;
    logic [IW-1:0]            idx_q, last_idx;
    logic                     net_q, v0_q, v1_q;
    logic [MAX_LAYERS-1:0]    outs_q;
    logic signed [ACC_W-1:0]  norm_q, acc, feat, mac_b;
    logic signed [WGT_W-1:0]  wgt, mac_a;
    logic                     mac_en, mac_clr, unit_bit;

    // Depth clamp (R4): 0 runs one layer, anything past the top runs all.
    always_comb begin
        if (cfg_depth == '0)                              depth_last = '0;
        else if (cfg_depth >= DEPTH_W'(MAX_LAYERS))       depth_last = LW'(MAX_LAYERS - 1);
        else                                              depth_last = LW'(cfg_depth - 1'b1);
    end

    // Term count per layer (R2)
    assign last_idx = (layer_q == '0) ? IW'(DIM) : IW'(DIM + 1) + IW'(layer_q);

    // Feature select by input index (R2)
    always_comb begin
        if (idx_q == '0)                 feat = ACC_W'(1);
        else if (idx_q <= IW'(DIM))      feat = ACC_W'(meas_q[MI'(idx_q - 1'b1)]);
        else if (idx_q == IW'(DIM + 1))  feat = norm_q;
        else                             feat = outs_q[LW'(idx_q - IW'(DIM + 2))] ? ACC_W'(1) : ACC_W'(-1);
    end

    assign mac_a    = (state_q == ST_SQR) ? WGT_W'(meas_q[MI'(idx_q)]) : wgt;
    assign mac_b    = (state_q == ST_SQR) ? ACC_W'(meas_q[MI'(idx_q)]) : feat;
    assign mac_en   = (state_q == ST_SQR) || (state_q == ST_MAC);
    assign mac_clr  = mac_en && (idx_q == '0);
    assign unit_bit = ~acc[ACC_W-1];

    ccp_weight_bank #(.LAYERS(MAX_LAYERS), .TERMS(TERMS), .WGT_W(WGT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && (state_q == ST_IDLE)),
        .wr_net   (wr_net),
        .wr_layer (wr_layer),
        .wr_index (wr_index),
        .wr_data  (wr_data),
        .rd_net   (net_q),
        .rd_layer (layer_q),
        .rd_index (idx_q),
        .rd_data  (wgt)
    );

    ccp_mac_unit #(.A_W(WGT_W), .B_W(ACC_W), .ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mac_en),
        .clr   (mac_clr),
        .a     (mac_a),
        .b     (mac_b),
        .acc   (acc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_SQR;
            ST_SQR:   if (idx_q == IW'(DIM - 1)) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_MAC;
            ST_MAC:   if (idx_q == last_idx) state_d = ST_SIGN;
            ST_SIGN:  state_d = (net_q && layer_q == last_layer_q) ? ST_DONE : ST_MAC;
            ST_DONE:  if (res_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DIM; i++) meas_q[i] <= '0;
            last_layer_q <= '0;
            layer_q      <= '0;
            idx_q        <= '0;
            net_q        <= 1'b0;
            v0_q         <= 1'b0;
            v1_q         <= 1'b0;
            outs_q       <= '0;
            norm_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_valid) begin
                    for (int i = 0; i < DIM; i++) meas_q[i] <= in_meas[i*MEAS_W +: MEAS_W];
                    last_layer_q <= depth_last;
                    idx_q        <= '0;
                end
                ST_SQR: idx_q <= (idx_q == IW'(DIM - 1)) ? '0 : idx_q + 1'b1;
                ST_LATCH: begin
                    norm_q  <= acc;
                    idx_q   <= '0;
                    layer_q <= '0;
                    net_q   <= 1'b0;
                end
                ST_MAC: if (idx_q != last_idx) idx_q <= idx_q + 1'b1;
                ST_SIGN: begin
                    outs_q[layer_q] <= unit_bit;
                    idx_q           <= '0;
                    if (layer_q == last_layer_q) begin
                        layer_q <= '0;
                        if (!net_q) begin
                            v0_q  <= unit_bit;
                            net_q <= 1'b1;
                        end else begin
                            v1_q  <= unit_bit;
                        end
                    end else begin
                        layer_q <= layer_q + 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign res_valid = (state_q == ST_DONE);

    always_comb begin
        if (!res_valid)          res_code = 2'b00;
        else if (v0_q && v1_q)   res_code = CODE_PASS;
        else if (!v0_q && !v1_q) res_code = CODE_FAIL;
        else                     res_code = CODE_RETEST;
    end
endmodule

// File: rtl/ccp_checker.sv
`timescale 1ns/1ps
module ccp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       res_valid,
    input logic       res_ready,
    input logic [1:0] res_code
);
    assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_code != 2'b00));

    assert_idle_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && res_valid));

    assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_code)));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> (in_ready && !res_valid));
endmodule

bind ccp_classifier ccp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_code  (res_code)
);

// File: tb/ccp_classifier_test.sv
`timescale 1ns/1ps
module ccp_classifier_test;
    localparam int DIM = 8;
    localparam int ML = 8;
    localparam int TERMS = DIM + ML + 1;
    localparam int MW = 16;
    localparam longint AMAX = (longint'(1) <<< 39) - 1;
    localparam longint AMIN = -(longint'(1) <<< 39);

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_net = 1'b0;
    logic [2:0] wr_layer = '0;
    logic [4:0] wr_index = '0;
    logic [15:0] wr_data = '0;
    logic [3:0] cfg_depth = '0;
    logic in_valid = 1'b0, res_ready = 1'b1;
    logic [DIM*MW-1:0] in_meas = '0;
    logic in_ready, res_valid;
    logic [1:0] res_code;

    ccp_classifier uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_net(wr_net), .wr_layer(wr_layer),
        .wr_index(wr_index), .wr_data(wr_data), .cfg_depth(cfg_depth),
        .in_valid(in_valid), .in_ready(in_ready), .in_meas(in_meas),
        .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { logic [1:0] code; int lat; string tag; } exp_t;
    exp_t sb[$];
    longint wm [2][ML][TERMS];
    longint xv [DIM];
    int errors = 0, checks = 0, accept_cyc = 0;
    bit prev_v = 1'b0;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(longint v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    function automatic int eff_depth(int d);
        if (d == 0) return 1;
        if (d > ML) return ML;
        return d;
    endfunction

    // Reference per R1, R2, R3
    function automatic bit eval_net(int n, int dep);
        longint norm = 0, acc, f;
        bit o [ML];
        int nt;
        for (int i = 0; i < DIM; i++) norm = sat(norm + xv[i] * xv[i]);
        for (int k = 0; k < dep; k++) begin
            acc = 0;
            nt = (k == 0) ? DIM + 1 : DIM + 2 + k;
            for (int j = 0; j < nt; j++) begin
                if (j == 0) f = 1;
                else if (j <= DIM) f = xv[j-1];
                else if (j == DIM + 1) f = norm;
                else f = o[j-DIM-2] ? 1 : -1;
                acc = sat(acc + wm[n][k][j] * f);
            end
            o[k] = (acc >= 0);
        end
        return o[dep-1];
    endfunction

    function automatic int exp_lat(int dep);
        int s = 0;
        for (int k = 0; k < dep; k++) s += ((k == 0) ? DIM + 1 : DIM + 2 + k) + 1;
        return DIM + 1 + 2 * s;
    endfunction

    function automatic logic [1:0] exp_code(int dep);
        bit a, b;
        a = eval_net(0, dep);
        b = eval_net(1, dep);
        if (a && b) return 2'b01;
        if (!a && !b) return 2'b10;
        return 2'b11;
    endfunction

    task automatic wr_raw(int n, int l, int i, longint d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_net = n[0]; wr_layer = l[2:0]; wr_index = i[4:0]; wr_data = d[15:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr(int n, int l, int i, longint d);
        wr_raw(n, l, i, d);
        if (i < TERMS) wm[n][l][i] = d;
    endtask

    task automatic clear_weights();
        for (int n = 0; n < 2; n++)
            for (int l = 0; l < ML; l++)
                for (int t = 0; t < TERMS; t++)
                    if (wm[n][l][t] != 0) wr(n, l, t, 0);
    endtask

    task automatic set_x(longint v);
        for (int i = 0; i < DIM; i++) xv[i] = v;
    endtask

    task automatic start_vec(int depth, string tag);
        exp_t e;
        e.code = exp_code(eff_depth(depth));
        e.lat = exp_lat(eff_depth(depth));
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        for (int i = 0; i < DIM; i++) in_meas[i*MW +: MW] = xv[i][15:0];
        cfg_depth = depth[3:0];
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        accept_cyc = cyc;
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (sb.size() > 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic run(int depth, string tag);
        start_vec(depth, tag);
        wait_done();
    endtask

    // Monitor: scoreboard compare
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (res_valid && !prev_v) begin
                    if (sb.size() == 0) check(1'b0, "R7 unexpected result", 1, 0);
                    else check((cyc - accept_cyc) == sb[0].lat, {"R6 latency ", sb[0].tag},
                               cyc - accept_cyc, sb[0].lat);
                end
                if (res_valid && res_ready && sb.size() > 0) begin
                    check(res_code == sb[0].code, {"R5 code ", sb[0].tag}, res_code, sb[0].code);
                    void'(sb.pop_front());
                end
                prev_v = res_valid;
            end
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int n = 0; n < 2; n++)
            for (int l = 0; l < ML; l++)
                for (int t = 0; t < TERMS; t++) wm[n][l][t] = 0;
        set_x(0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
        check(res_valid == 1'b0, "R10 res_valid after reset", res_valid, 0);
        set_x(123);
        run(1, "R10 zero weights pass");

        // R5 agreement and disagreement
        wr(0, 0, 0, 5); wr(1, 0, 0, 5);
        run(1, "R5 both nominal");
        wr(0, 0, 0, -5); wr(1, 0, 0, -5);
        run(1, "R5 both faulty");
        wr(0, 0, 0, 5);
        run(1, "R5 disagree retest");

        // R1 threshold at exactly zero
        clear_weights();
        wr(0, 0, 0, -4); wr(0, 0, 1, 2); wr(1, 0, 0, -4); wr(1, 0, 1, 2);
        set_x(0); xv[0] = 2;
        run(1, "R1 sum zero is nominal");
        xv[0] = 1;
        run(1, "R1 negative sum faulty");

        // R2 / R4 cascade features and depth
        clear_weights();
        wr(0, 0, 0, -1); wr(1, 0, 0, -1);
        wr(0, 1, 10, 3); wr(1, 1, 10, 3);
        set_x(0); xv[3] = 2;
        run(1, "R4 depth 1 uses layer 0");
        run(2, "R2 earlier output feeds layer 1");
        wr(0, 1, 9, 1);
        run(2, "R2 norm index feeds layer 1");
        wr(1, 1, 4, 2);
        run(2, "R2 measurement index in layer 1");
        run(0, "R4 depth 0 clamps to 1");
        run(15, "R4 depth above max clamps");

        // R3 saturation changes the decision
        clear_weights();
        for (int n = 0; n < 2; n++) begin
            wr(n, 0, 0, 1); wr(n, 1, 9, 32767); wr(n, 1, 10, 32767);
        end
        set_x(32767);
        run(2, "R3 positive saturation holds");
        wr(1, 1, 9, -32768); wr(1, 1, 10, -32768);
        run(2, "R3 negative saturation holds");

        // R9 writes while busy are ignored
        clear_weights();
        wr(0, 0, 0, 5); wr(1, 0, 0, 5);
        set_x(7);
        start_vec(1, "R9 before busy write");
        wr_raw(0, 0, 0, -5);
        wr_raw(1, 0, 0, -5);
        wait_done();
        run(1, "R9 busy write ignored");
        wr_raw(0, 0, 17, -9);
        run(1, "R9 out of range index ignored");

        // R7 vectors offered while busy are ignored
        start_vec(1, "R7 first vector");
        @(posedge clk); #1;
        in_valid = 1'b1;
        repeat (6) @(posedge clk);
        #1 in_valid = 1'b0;
        wait_done();
        repeat (60) @(negedge clk);
        check(res_valid == 1'b0, "R7 no extra result", res_valid, 0);
        check(in_ready == 1'b1, "R7 idle after single result", in_ready, 1);

        // R8 result held until accepted
        wr(1, 0, 0, -5);
        res_ready = 1'b0;
        start_vec(1, "R8 held result");
        while (!res_valid) @(negedge clk);
        repeat (10) @(negedge clk);
        check(res_valid == 1'b1, "R8 valid held", res_valid, 1);
        check(res_code == 2'b11, "R8 code held", res_code, 2'b11);
        check(in_ready == 1'b0, "R8 busy while held", in_ready, 0);
        @(posedge clk); #1 res_ready = 1'b1;
        wait_done();

        // Mixed patterns
        for (int r = 0; r < 12; r++) begin
            for (int n = 0; n < 2; n++)
                for (int l = 0; l < ML; l++)
                    for (int t = 0; t < TERMS; t++)
                        wr(n, l, t, longint'($urandom_range(0, 255)) - 128);
            for (int i = 0; i < DIM; i++) xv[i] = longint'($urandom_range(0, 2047)) - 1024;
            run(int'($urandom_range(1, ML)), "R2 mixed pattern");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule